// File: doc/BRIEF.md
# Two-Sequence Playback Controller

This block sequences playback for a multi-channel pulse-width generator that draws its duty values from two stored sequences, numbered 0 and 1. It takes single-cycle task pulses (start sequence 0, start sequence 1, stop, advance one step), watches two strobes from its neighbours (the generator's period boundary and the decoder's "that fetch was the last value of the sequence" marker), and tells the decoder when to fetch the next value. It reports what it is doing as single-cycle event pulses. Each event also sets a sticky flag, and a per-event enable mask turns the flags into one interrupt line.

A nonzero loop count makes sequence 0 and then sequence 1 play as one unit, repeated that many times, and a loops-done event marks the end. With a loop count of zero, a started sequence plays once and the generator then holds its last value. Each value can be held for extra periods (a per-sequence repeat count), and a per-sequence end delay can be added after a sequence finishes. In triggered-step mode, only the step task advances the sequence. A shortcut mask turns chosen events into tasks one cycle later, so playback can stop or restart itself with no processor involved.

Top module: `dual_seq_player`

## Requirements
- R1: A start task puts `runOut` high in the next cycle. In that same cycle the block shows the chosen sequence on `activeSeq`, pulses `fetchReq` and pulses that sequence's started event (`evtOut[1]` for sequence 0, `evtOut[2]` for sequence 1). The loop counter reloads from `loopCfg` on every start.
- R2: A stop task while playing takes effect only at the next `periodEnd`. In the cycle after that boundary, `runOut` is low and the stopped event `evtOut[0]` pulses. A stop while idle pulses `evtOut[0]` in the next cycle.
- R3: The sequence-end event (`evtOut[3]` for sequence 0, `evtOut[4]` for sequence 1) pulses in the cycle after `lastRead`. This is when the last value is read, not when it finishes playing.
- R4: In automatic mode each value plays for 1 + repeat-count periods. The next fetch is requested at the boundary that closes the last of those periods.
- R5: In automatic mode, after a sequence's last value has played, the block waits that sequence's end-delay count of extra periods before moving on.
- R6: With `loopCfg` = N > 0, sequence 0 then sequence 1 play N times. The loops-done event `evtOut[6]` then pulses once and the generator holds its last value.
- R7: At the end of the final loop, the last value of sequence 1 plays for one period only, and no end delay follows before loops-done.
- R8: With `loopCfg` = 0, a started sequence plays once. After it, no further fetch is requested while `runOut` stays high.
- R9: With `stepTriggered` high, only the step task advances the sequence. Repeat counts and end delays are ignored.
- R10: Shortcut bits in `shortMask` act in the cycle after their source event, as an external task pulse would. Bit 0 is sequence-end 0 to stop, bit 1 is sequence-end 1 to stop, bit 2 is loops-done to start 0, bit 3 is loops-done to start 1, and bit 4 is loops-done to stop.
- R11: The period-end event `evtOut[5]` pulses in the cycle after each `periodEnd` while `runOut` is high. It does not pulse while idle.
- R12: Each `evtFlags` bit is set together with its event. It stays set until its `flagClear` bit is pulsed, and a set wins over a clear in the same cycle. `irq` is the OR of `evtFlags & intEnable`.
- R13: When tasks coincide, a start beats a stop, and start 0 beats start 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startSeq0 | input | 1 | Task pulse: start sequence 0 |
| startSeq1 | input | 1 | Task pulse: start sequence 1 |
| stopReq | input | 1 | Task pulse: stop at the next period boundary |
| nextStep | input | 1 | Task pulse: advance one value (triggered mode) |
| periodEnd | input | 1 | Strobe from the generator: a period just ended |
| lastRead | input | 1 | Strobe from the decoder: the value just fetched was the sequence's last |
| stepTriggered | input | 1 | 1 = advance on step task, 0 = advance on repeat count |
| loopCfg | input | 16 | Number of seq0+seq1 loops, 0 = no looping |
| refresh0 | input | 8 | Extra periods per value, sequence 0 |
| refresh1 | input | 8 | Extra periods per value, sequence 1 |
| endDelay0 | input | 8 | Periods added after sequence 0 |
| endDelay1 | input | 8 | Periods added after sequence 1 |
| shortMask | input | 5 | Event-to-task shortcut enables |
| intEnable | input | 7 | Per-event interrupt enables |
| flagClear | input | 7 | Per-event sticky-flag clear pulses |
| runOut | output | 1 | Generator enable |
| activeSeq | output | 1 | Sequence currently selected |
| fetchReq | output | 1 | Pulse: decoder shall load the next value |
| evtOut | output | 7 | Event pulses: 0 stopped, 1/2 started 0/1, 3/4 end 0/1, 5 period end, 6 loops done |
| evtFlags | output | 7 | Sticky event flags, same bit order |
| irq | output | 1 | Interrupt request |

## Verification
A wrong repeat or delay counter shows up as a `fetchReq` or a started event landing one or more periods early or late. The reference model flags this at the first mismatching clock, never later than the following period boundary. A bad loop counter either suppresses loops-done or replays a sequence, which the per-cycle comparison of `activeSeq` and `evtOut` exposes on the cycle where the unit should have ended. A stuck control state shows as `runOut` failing to fall at the boundary after a stop, or as fetches continuing after a single-shot sequence. Flag and interrupt faults appear on `evtFlags` and `irq` in the same cycle as the event that should have set them.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int NUM_EVT    = 7;
  localparam int NUM_SHORT  = 5;

  // event bit positions, decoded by software and by the shortcut logic
  localparam int EV_STOPPED = 0;
  localparam int EV_START0  = 1;
  localparam int EV_START1  = 2;
  localparam int EV_END0    = 3;
  localparam int EV_END1    = 4;
  localparam int EV_PERIOD  = 5;
  localparam int EV_LOOPS   = 6;

  // shortcut bit positions
  localparam int SC_END0_STOP   = 0;
  localparam int SC_END1_STOP   = 1;
  localparam int SC_LOOPS_GO0   = 2;
  localparam int SC_LOOPS_GO1   = 3;
  localparam int SC_LOOPS_STOP  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DELAY = 3'd2,
    ST_HOLD  = 3'd3,
    ST_HALT  = 3'd4
  } play_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                loadLoop;
    logic                decLoop;
    logic                clrRep;
    logic                incRep;
    logic                clrDly;
    logic                incDly;
    logic                fetch;
    logic [NUM_EVT-1:0]  evt;
  } ctrl_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic repMore;
    logic dlyLast;
    logic dlyZero;
    logic loopOne;
    logic loopZero;
  } dp_status_t;

endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startSeq0,
  input  logic         startSeq1,
  input  logic         stopReq,
  input  logic         nextStep,
  input  logic         periodEnd,
  input  logic         lastRead,
  input  logic         stepTriggered,
  input  logic [NUM_SHORT-1:0] shortMask,
  input  logic         fbEnd0,
  input  logic         fbEnd1,
  input  logic         fbLoops,
  input  dp_status_t   sts,
  output ctrl_strobe_t stb,
  output logic         seqSel,
  output logic         runOut
);

  play_state_e state, stateNext;
  logic        selNext;
  logic        lastSeen, lastNext;

  logic goSeq0, goSeq1, goStop;
  logic advance, wrapUp, finalUnit, finalVal;

  // shortcuts: last cycle's events act like task pulses now
  assign goSeq0 = startSeq0 | (shortMask[SC_LOOPS_GO0] & fbLoops);
  assign goSeq1 = startSeq1 | (shortMask[SC_LOOPS_GO1] & fbLoops);
  assign goStop = stopReq
                | (shortMask[SC_END0_STOP]  & fbEnd0)
                | (shortMask[SC_END1_STOP]  & fbEnd1)
                | (shortMask[SC_LOOPS_STOP] & fbLoops);

  assign finalUnit = sts.loopOne & seqSel;
  assign finalVal  = finalUnit & lastSeen;

  always_comb begin
    stateNext = state;
    selNext   = seqSel;
    lastNext  = lastSeen;
    stb       = '0;
    advance   = 1'b0;
    wrapUp    = 1'b0;

    if (goSeq0 | goSeq1) begin
      selNext      = ~goSeq0;
      stateNext    = ST_RUN;
      lastNext     = 1'b0;
      stb.loadLoop = 1'b1;
      stb.clrRep   = 1'b1;
      stb.fetch    = 1'b1;
      stb.evt[goSeq0 ? EV_START0 : EV_START1] = 1'b1;
    end else if (goStop) begin
      if (state == ST_IDLE) stb.evt[EV_STOPPED] = 1'b1;
      else                  stateNext = ST_HALT;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (lastRead) begin
            lastNext = 1'b1;
            stb.evt[seqSel ? EV_END1 : EV_END0] = 1'b1;
          end
          if (periodEnd) stb.evt[EV_PERIOD] = 1'b1;
          if (stepTriggered) begin
            advance = nextStep;
          end else if (periodEnd) begin
            if (sts.repMore && !finalVal) stb.incRep = 1'b1;
            else                          advance    = 1'b1;
          end
          if (advance) begin
            stb.clrRep = 1'b1;
            if (!lastSeen) begin
              stb.fetch = 1'b1;
            end else if (finalUnit) begin
              stb.evt[EV_LOOPS] = 1'b1;
              stateNext = ST_HOLD;
            end else if (!stepTriggered && !sts.dlyZero) begin
              stb.clrDly = 1'b1;
              stateNext  = ST_DELAY;
            end else begin
              wrapUp = 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (periodEnd) begin
            stb.evt[EV_PERIOD] = 1'b1;
            if (sts.dlyLast) wrapUp     = 1'b1;
            else             stb.incDly = 1'b1;
          end
        end
        ST_HOLD: begin
          if (periodEnd) stb.evt[EV_PERIOD] = 1'b1;
        end
        ST_HALT: begin
          if (periodEnd) begin
            stb.evt[EV_PERIOD]  = 1'b1;
            stb.evt[EV_STOPPED] = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        default: ;
      endcase

      // a sequence has fully played: hold, hand over, or close a loop
      if (wrapUp) begin
        if (sts.loopZero) begin
          stateNext = ST_HOLD;
        end else begin
          stateNext  = ST_RUN;
          selNext    = ~seqSel;
          lastNext   = 1'b0;
          stb.clrRep = 1'b1;
          stb.fetch  = 1'b1;
          if (!seqSel) begin
            stb.evt[EV_START1] = 1'b1;
          end else begin
            stb.decLoop        = 1'b1;
            stb.evt[EV_START0] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seqSel   <= 1'b0;
      lastSeen <= 1'b0;
    end else begin
      state    <= stateNext;
      seqSel   <= selNext;
      lastSeen <= lastNext;
    end
  end

  assign runOut = (state != ST_IDLE);

  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(runOut) |-> $past(periodEnd)) else $error("run fell off a period boundary"); // R2

  AST_DELAY_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |-> !$past(stepTriggered) || $past(state == ST_DELAY)) else $error("delay entered in triggered mode"); // R9

endmodule

// File: rtl/dsp_dpath.sv
module dsp_dpath
  import dsp_pkg::*;
#(
  parameter int LOOP_W = 16,
  parameter int REP_W  = 8,
  parameter int DLY_W  = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_strobe_t       stb,
  input  logic               seqSel,
  input  logic [LOOP_W-1:0]  loopCfg,
  input  logic [REP_W-1:0]   refresh0,
  input  logic [REP_W-1:0]   refresh1,
  input  logic [DLY_W-1:0]   endDelay0,
  input  logic [DLY_W-1:0]   endDelay1,
  input  logic [NUM_EVT-1:0] intEnable,
  input  logic [NUM_EVT-1:0] flagClear,
  output dp_status_t         sts,
  output logic [NUM_EVT-1:0] evtOut,
  output logic [NUM_EVT-1:0] evtFlags,
  output logic               fetchReq,
  output logic               irq
);

  localparam logic [LOOP_W-1:0] LOOP_ONE = LOOP_W'(1);

  logic [LOOP_W-1:0] loopRem;
  logic [REP_W-1:0]  repCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic [REP_W-1:0]  refreshSel;
  logic [DLY_W-1:0]  delaySel;

  assign refreshSel = seqSel ? refresh1  : refresh0;
  assign delaySel   = seqSel ? endDelay1 : endDelay0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loopRem <= '0;
      repCnt  <= '0;
      dlyCnt  <= '0;
    end else begin
      if (stb.loadLoop)     loopRem <= loopCfg;
      else if (stb.decLoop) loopRem <= loopRem - LOOP_ONE;
      if (stb.clrRep)       repCnt  <= '0;
      else if (stb.incRep)  repCnt  <= repCnt + REP_W'(1);
      if (stb.clrDly)       dlyCnt  <= '0;
      else if (stb.incDly)  dlyCnt  <= dlyCnt + DLY_W'(1);
    end
  end

  assign sts.repMore  = (repCnt < refreshSel);
  assign sts.dlyLast  = ({1'b0, dlyCnt} + (DLY_W+1)'(1)) == {1'b0, delaySel};
  assign sts.dlyZero  = (delaySel == '0);
  assign sts.loopOne  = (loopRem == LOOP_ONE);
  assign sts.loopZero = (loopRem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtOut   <= '0;
      fetchReq <= 1'b0;
    end else begin
      evtOut   <= stb.evt;
      fetchReq <= stb.fetch;
    end
  end

  // one sticky flag per event; a new event beats a clear
  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evtFlags[gi] <= 1'b0;
      else        evtFlags[gi] <= stb.evt[gi] | (evtFlags[gi] & ~flagClear[gi]);
    end
  end

  assign irq = |(evtFlags & intEnable);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(evtFlags) & ~$past(flagClear)) & ~evtFlags) == '0)) else $error("flag dropped without clear"); // R12

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.incRep) |-> (repCnt != '0)) else $error("repeat counter wrapped"); // R4

endmodule

// File: rtl/dual_seq_player.sv
module dual_seq_player
  import dsp_pkg::*;
#(
  parameter int LOOP_W = 16,
  parameter int REP_W  = 8,
  parameter int DLY_W  = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startSeq0,
  input  logic               startSeq1,
  input  logic               stopReq,
  input  logic               nextStep,
  input  logic               periodEnd,
  input  logic               lastRead,
  input  logic               stepTriggered,
  input  logic [LOOP_W-1:0]  loopCfg,
  input  logic [REP_W-1:0]   refresh0,
  input  logic [REP_W-1:0]   refresh1,
  input  logic [DLY_W-1:0]   endDelay0,
  input  logic [DLY_W-1:0]   endDelay1,
  input  logic [4:0]         shortMask,
  input  logic [6:0]         intEnable,
  input  logic [6:0]         flagClear,
  output logic               runOut,
  output logic               activeSeq,
  output logic               fetchReq,
  output logic [6:0]         evtOut,
  output logic [6:0]         evtFlags,
  output logic               irq
);

  ctrl_strobe_t stb;
  dp_status_t   sts;

  dsp_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .startSeq0     (startSeq0),
    .startSeq1     (startSeq1),
    .stopReq       (stopReq),
    .nextStep      (nextStep),
    .periodEnd     (periodEnd),
    .lastRead      (lastRead),
    .stepTriggered (stepTriggered),
    .shortMask     (shortMask),
    .fbEnd0        (evtOut[EV_END0]),
    .fbEnd1        (evtOut[EV_END1]),
    .fbLoops       (evtOut[EV_LOOPS]),
    .sts           (sts),
    .stb           (stb),
    .seqSel        (activeSeq),
    .runOut        (runOut)
  );

  dsp_dpath #(
    .LOOP_W (LOOP_W),
    .REP_W  (REP_W),
    .DLY_W  (DLY_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .seqSel    (activeSeq),
    .loopCfg   (loopCfg),
    .refresh0  (refresh0),
    .refresh1  (refresh1),
    .endDelay0 (endDelay0),
    .endDelay1 (endDelay1),
    .intEnable (intEnable),
    .flagClear (flagClear),
    .sts       (sts),
    .evtOut    (evtOut),
    .evtFlags  (evtFlags),
    .fetchReq  (fetchReq),
    .irq       (irq)
  );

  AST_SEQEND_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (evtOut[EV_END0] | evtOut[EV_END1]) |-> $past(lastRead)) else $error("sequence end without last read"); // R3

  AST_STOPPED_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evtOut[EV_STOPPED] |-> !runOut) else $error("stopped while running"); // R2

  AST_ONE_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evtOut[EV_START1:EV_START0])) else $error("two sequences started"); // R13

  AST_FETCH_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq |-> runOut) else $error("fetch while idle"); // R1

endmodule

// File: tb/dual_seq_player_tb.sv
module dual_seq_player_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        startSeq0 = 0, startSeq1 = 0, stopReq = 0, nextStep = 0;
  logic        periodEnd = 0, lastRead = 0, stepTriggered = 0;
  logic [15:0] loopCfg = 0;
  logic [7:0]  refresh0 = 0, refresh1 = 0, endDelay0 = 0, endDelay1 = 0;
  logic [4:0]  shortMask = 0;
  logic [6:0]  intEnable = 0, flagClear = 0;
  logic        runOut, activeSeq, fetchReq, irq;
  logic [6:0]  evtOut, evtFlags;

  dual_seq_player u_dut (
    .clk(clk), .rst_n(rst_n), .startSeq0(startSeq0), .startSeq1(startSeq1),
    .stopReq(stopReq), .nextStep(nextStep), .periodEnd(periodEnd), .lastRead(lastRead),
    .stepTriggered(stepTriggered), .loopCfg(loopCfg), .refresh0(refresh0), .refresh1(refresh1),
    .endDelay0(endDelay0), .endDelay1(endDelay1), .shortMask(shortMask),
    .intEnable(intEnable), .flagClear(flagClear), .runOut(runOut), .activeSeq(activeSeq),
    .fetchReq(fetchReq), .evtOut(evtOut), .evtFlags(evtFlags), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int len0 = 1, len1 = 1;
  int dcnt = 0;
  int periodPh = 0;
  int evCnt [7];
  int fetchCnt = 0;
  bit modelOn = 0;

  // ---------------- behavioural reference ----------------
  int       mMode;      // 0 idle, 1 playing, 2 trailing delay, 3 holding, 4 stopping
  int       mSeq, mLoops, mRepeats, mWait;
  bit       mGotLast;
  bit [6:0] mEv, mFlags;
  bit       mFetch;

  task automatic model_reset();
    mMode = 0; mSeq = 0; mLoops = 0; mRepeats = 0; mWait = 0;
    mGotLast = 0; mEv = '0; mFlags = '0; mFetch = 0;
  endtask

  task automatic begin_seq(input int s, inout bit [6:0] ev, inout bit fe);
    mSeq = s; mMode = 1; mGotLast = 0; mRepeats = 0; fe = 1;
    ev[s == 0 ? 1 : 2] = 1;
  endtask

  task automatic model_step();
    bit [6:0] ev = '0;
    bit fe = 0;
    bit go0, go1, halt, was, done;
    int rep, dl;
    go0  = startSeq0 || (shortMask[2] && mEv[6]);
    go1  = startSeq1 || (shortMask[3] && mEv[6]);
    halt = stopReq || (shortMask[0] && mEv[3]) || (shortMask[1] && mEv[4]) || (shortMask[4] && mEv[6]);
    rep  = (mSeq == 1) ? int'(refresh1) : int'(refresh0);
    dl   = (mSeq == 1) ? int'(endDelay1) : int'(endDelay0);
    done = 0;
    if (go0 || go1) begin
      mLoops = loopCfg;
      begin_seq(go0 ? 0 : 1, ev, fe);
    end else if (halt) begin
      if (mMode == 0) ev[0] = 1; else mMode = 4;
    end else if (mMode == 1) begin
      bit lastRound, step;
      was = mGotLast;
      lastRound = (mLoops == 1) && (mSeq == 1);
      if (lastRead) begin mGotLast = 1; ev[mSeq == 1 ? 4 : 3] = 1; end
      if (periodEnd) ev[5] = 1;
      step = 0;
      if (stepTriggered) step = nextStep;
      else if (periodEnd) begin
        if (mRepeats < rep && !(lastRound && was)) mRepeats++;
        else step = 1;
      end
      if (step) begin
        mRepeats = 0;
        if (!was) fe = 1;
        else if (lastRound) begin ev[6] = 1; mMode = 3; end
        else if (!stepTriggered && dl != 0) begin mMode = 2; mWait = 0; end
        else done = 1;
      end
    end else if (mMode == 2) begin
      if (periodEnd) begin
        ev[5] = 1;
        if (mWait + 1 == dl) done = 1; else mWait++;
      end
    end else if (mMode == 3) begin
      if (periodEnd) ev[5] = 1;
    end else if (mMode == 4) begin
      if (periodEnd) begin ev[5] = 1; ev[0] = 1; mMode = 0; end
    end
    if (done) begin
      if (mLoops == 0) mMode = 3;
      else if (mSeq == 0) begin_seq(1, ev, fe);
      else begin mLoops--; begin_seq(0, ev, fe); end
    end
    mFlags = ev | (mFlags & ~bit'(0) & ~flagClear);
    mEv = ev;
    mFetch = fe;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_up();
    end
    if (modelOn) begin
      check("R2",  "runOut",    runOut,    (mMode != 0));
      check("R6",  "activeSeq", activeSeq, mSeq);
      check("R4",  "fetchReq",  fetchReq,  mFetch);
      check("R11", "evtOut",    evtOut,    mEv);
      check("R12", "evtFlags",  evtFlags,  mFlags);
      check("R12", "irq",       irq,       |(mFlags & intEnable));
      for (int i = 0; i < 7; i++) evCnt[i] += evtOut[i];
      fetchCnt += fetchReq;
    end
    #1;
    // period strobe from the generator, every 4 cycles
    periodPh = (periodPh + 1) % 4;
    periodEnd = (periodPh == 0);
    // decoder emulation: flag the fetch that carried the last value
    lastRead = 0;
    if (evtOut[1] || evtOut[2]) dcnt = 1;
    else if (fetchReq) dcnt++;
    if ((evtOut[1] || evtOut[2] || fetchReq) && dcnt == (activeSeq ? len1 : len0)) lastRead = 1;
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 7; i++) evCnt[i] = 0;
    fetchCnt = 0;
  endtask

  task automatic pulse_stop();
    stopReq = 1; tick(); stopReq = 0;
  endtask

  task automatic pulse_start(input bit s);
    if (s) startSeq1 = 1; else startSeq0 = 1;
    tick();
    startSeq0 = 0; startSeq1 = 0;
  endtask

  task automatic pulse_step();
    nextStep = 1; tick(); nextStep = 0;
  endtask

  initial begin
    clear_counts();
    tick(3);
    // reset state
    check("R1", "reset runOut", runOut, 0);
    check("R11", "reset evtOut", evtOut, 0);
    check("R12", "reset flags", evtFlags, 0);
    check("R12", "reset irq", irq, 0);
    rst_n = 1;
    modelOn = 1;
    tick(2);

    // R2: stop while idle
    stopReq = 1;
    @(negedge clk);
    check("R2", "stopped pulse when idle", evtOut[0], 1);
    #2 stopReq = 0;
    tick(2);

    // R1 / R3 / R4 / R8: single sequence 0, three values, one repeat each
    len0 = 3; refresh0 = 1; endDelay0 = 0; loopCfg = 0;
    clear_counts();
    startSeq0 = 1;
    @(negedge clk);
    check("R1", "run after start", runOut, 1);
    check("R1", "started0 pulse", evtOut[1], 1);
    check("R1", "first fetch", fetchReq, 1);
    #2 startSeq0 = 0;
    tick(60);
    check("R4", "fetch count single", fetchCnt, 3);
    check("R3", "seqend0 count", evCnt[3], 1);
    check("R8", "still holding", runOut, 1);
    clear_counts();
    tick(40);
    check("R8", "no fetch while holding", fetchCnt, 0);
    check("R11", "periods while holding", (evCnt[5] >= 9) ? 1 : 0, 1);
    clear_counts();
    pulse_stop();
    tick(10);
    check("R2", "run low after stop", runOut, 0);
    check("R2", "stopped count", evCnt[0], 1);

    // R5 / R6 / R7: two loops with end delays
    len0 = 2; len1 = 1; refresh0 = 0; refresh1 = 0; endDelay0 = 1; endDelay1 = 1; loopCfg = 2;
    clear_counts();
    pulse_start(0);
    tick(100);
    check("R6", "started0 in loop", evCnt[1], 2);
    check("R6", "started1 in loop", evCnt[2], 2);
    check("R6", "seqend1 in loop", evCnt[4], 2);
    check("R6", "loops done", evCnt[6], 1);
    check("R7", "fetches in loop", fetchCnt, 6);
    pulse_stop(); tick(10);

    // R10: loops-done -> stop
    len0 = 1; len1 = 1; endDelay0 = 0; endDelay1 = 0; loopCfg = 1; shortMask = 5'b10000;
    clear_counts();
    pulse_start(0);
    tick(80);
    check("R10", "loopsdone stop count", evCnt[0], 1);
    check("R10", "run low via shortcut", runOut, 0);

    // R10: seq-end 0 -> stop cuts playback short
    len0 = 2; refresh0 = 3; loopCfg = 0; shortMask = 5'b00001;
    clear_counts();
    pulse_start(0);
    tick(60);
    check("R10", "end0 stop count", evCnt[0], 1);
    check("R10", "end0 stop fetches", fetchCnt, 2);
    shortMask = 0;

    // R9: triggered stepping ignores repeat and delay
    stepTriggered = 1; len0 = 2; refresh0 = 5; endDelay0 = 5;
    clear_counts();
    pulse_start(0);
    tick(20);
    check("R9", "no auto advance", fetchCnt, 1);
    pulse_step(); tick(20);
    check("R9", "step fetch", fetchCnt, 2);
    pulse_step(); tick(20);
    check("R9", "no further fetch", fetchCnt, 2);
    check("R9", "holding after last step", runOut, 1);
    pulse_stop(); tick(10);
    stepTriggered = 0;

    // R12: flags and interrupt
    flagClear = 7'h7f; tick(); flagClear = 0;
    check("R12", "flags cleared", evtFlags, 0);
    intEnable = 7'h01;
    pulse_stop(); tick();
    check("R12", "irq from stopped", irq, 1);
    tick(5);
    check("R12", "flag sticky", evtFlags[0], 1);
    flagClear = 7'h01; tick(); flagClear = 0;
    check("R12", "irq after clear", irq, 0);
    intEnable = 0;

    // R13: simultaneous tasks
    startSeq0 = 1; startSeq1 = 1; stopReq = 1;
    @(negedge clk);
    check("R13", "start beats stop", runOut, 1);
    check("R13", "seq0 wins", activeSeq, 0);
    check("R13", "only started0", evtOut[2:1], 1);
    #2 startSeq0 = 0; startSeq1 = 0; stopReq = 0;
    pulse_stop(); tick(10);

    // R10: loops-done -> start0 restarts by itself
    len0 = 1; len1 = 1; refresh0 = 0; loopCfg = 1; shortMask = 5'b00100;
    clear_counts();
    pulse_start(1);
    tick(120);
    check("R10", "restart via shortcut", (evCnt[1] >= 2) ? 1 : 0, 1);
    check("R1", "loop reload each start", (evCnt[6] >= 2) ? 1 : 0, 1);
    shortMask = 0;
    pulse_stop(); tick(10);
    check("R2", "final stop", runOut, 0);

    finish_up();
  end

endmodule